// File: doc/BRIEF.md
# Partitioned Bidirectional Tagged FIFO

This block keeps two first-in first-out queues in one shared storage array of 128 entries. Each entry is nine bits wide: an eight-bit payload plus a tag bit that marks the entry as a command or as plain data. The inbound queue carries traffic from an external host to a local processor. The outbound queue carries traffic the other way. Each side writes either data or a command through separate strobes, and reads whatever the other side queued. Every entry it reads comes with its tag.

A boundary register sets how the array is split. Addresses below the boundary belong to the inbound queue. Addresses from the boundary up to the top of the array belong to the outbound queue. The local side may change the boundary only while the freeze input is high. Any accepted change empties both queues and moves their pointers to the bottom of their new ranges. A boundary of zero leaves the inbound queue no array space. That queue then uses a single holding register instead. Each queue reports its fill count together with full and empty flags. A one-cycle error strobe flags any write to a full queue and any read from an empty queue.

Top module: `ptag_fifo`

## Requirements
- R1: After reset, both counts are 0, both empty flags are 1, both full flags are 0, all four error strobes are 0, both read-data outputs are 0, and the boundary is 64.
- R2: A host data write stores {0, byte} in the inbound queue and a host command write stores {1, byte}. Local reads return these in write order on `loc_rdata` (bit 8 = tag, bits 7:0 = payload), valid from the clock edge that accepts the read.
- R3: A local data write stores {0, byte} in the outbound queue and a local command write stores {1, byte}. Host reads return these in write order on `host_rdata`, with the same encoding and timing as in R2.
- R4: The inbound queue holds as many entries as the boundary value and the outbound queue holds 128 minus the boundary. The full flag rises exactly when the count reaches that capacity.
- R5: A write to a full queue is dropped and the queue's count is unchanged. The queue's overflow strobe (`host_ovf` for inbound, `loc_ovf` for outbound) goes high for one cycle after that edge.
- R6: A read from an empty queue is dropped and the read-data output holds its last value. The underflow strobe (`loc_unf` for inbound, `host_unf` for outbound) goes high for one cycle after that edge.
- R7: A boundary write while `freeze` is 1 loads the new boundary and clears both queues, so both counts are 0 after that edge.
- R8: A boundary write while `freeze` is 0 is ignored: the boundary and both queues' contents stay as they were.
- R9: Each queue's pointers wrap inside the queue's own address range. Order is kept across any number of wraps.
- R10: With the boundary at 0, the inbound queue is a single holding register (capacity 1) and the outbound queue spans all 128 entries.
- R11: Accesses to both queues in the same cycle each complete without disturbing the other. A read and a write to the same queue in one cycle leave its count unchanged.
- R12: If the data and command write strobes of one side are both high, exactly one entry is stored, and it is tagged as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_data | input | 1 | Host writes a data entry into the inbound queue |
| host_wr_cmd | input | 1 | Host writes a command entry into the inbound queue |
| host_wdata | input | 8 | Host write payload |
| host_rd | input | 1 | Host pops the outbound queue |
| host_rdata | output | 9 | Last entry popped by the host {tag, payload} |
| host_ovf | output | 1 | Host write hit a full inbound queue |
| host_unf | output | 1 | Host read hit an empty outbound queue |
| loc_wr_data | input | 1 | Local side writes a data entry into the outbound queue |
| loc_wr_cmd | input | 1 | Local side writes a command entry into the outbound queue |
| loc_wdata | input | 8 | Local write payload |
| loc_rd | input | 1 | Local side pops the inbound queue |
| loc_rdata | output | 9 | Last entry popped by the local side {tag, payload} |
| loc_ovf | output | 1 | Local write hit a full outbound queue |
| loc_unf | output | 1 | Local read hit an empty inbound queue |
| freeze | input | 1 | Enables boundary writes |
| bnd_we | input | 1 | Boundary write strobe |
| bnd_wdata | input | 7 | New boundary (first outbound address) |
| in_full | output | 1 | Inbound queue full |
| in_empty | output | 1 | Inbound queue empty |
| in_count | output | 8 | Inbound queue occupancy |
| out_full | output | 1 | Outbound queue full |
| out_empty | output | 1 | Outbound queue empty |
| out_count | output | 8 | Outbound queue occupancy |

## Verification
Every result lands on the clock edge that accepts the stimulus. That covers counts and flags, popped entries on both read-data outputs, the registered error strobes, and a boundary reload. Each is visible right after that one edge, and each strobe clears after the next. The bench changes inputs one nanosecond after a rising edge and reads outputs one nanosecond after the following rising edge. Each check therefore sees exactly one edge's worth of change. Drained entries and strobe fall-off are compared one edge at a time.

// File: rtl/ptf_pkg.sv
package ptf_pkg;

  // Tag bit stored above each payload byte
  typedef enum logic {
    TAG_DATA = 1'b0,
    TAG_CMD  = 1'b1
  } ptf_tag_e;

endpackage

// File: rtl/ptf_mem.sv
// Shared storage: one write and one registered read per queue per cycle.
module ptf_mem #(
  parameter int DEPTH = 128,
  parameter int EW    = 9,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_a,
  input  logic [AW-1:0] wa_a,
  input  logic [EW-1:0] wd_a,
  input  logic          we_b,
  input  logic [AW-1:0] wa_b,
  input  logic [EW-1:0] wd_b,
  input  logic          re_a,
  input  logic [AW-1:0] ra_a,
  output logic [EW-1:0] rd_a,
  input  logic          re_b,
  input  logic [AW-1:0] ra_b,
  output logic [EW-1:0] rd_b
);

  logic [EW-1:0] mem [DEPTH];

  // Array writes: the two queues never share an address
  always_ff @(posedge clk) begin
    if (we_a) mem[wa_a] <= wd_a;
    if (we_b) mem[wa_b] <= wd_b;
  end

  // Output registers, updated only on an accepted pop
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_a <= '0;
      rd_b <= '0;
    end else begin
      if (re_a) rd_a <= mem[ra_a];
      if (re_b) rd_b <= mem[ra_b];
    end
  end

endmodule

// File: rtl/ptf_chan.sv
// Pointer and occupancy control for one queue inside [base, last].
module ptf_chan #(
  parameter int AW = 7,
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reinit,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] last,
  input  logic [CW-1:0] cap,
  input  logic          wr,
  input  logic          rd,
  output logic          do_wr,
  output logic          do_rd,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          ovf,
  output logic          unf
);

  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  assign full  = (cnt_q == cap);
  assign empty = (cnt_q == '0);
  assign do_wr = wr && !full && !reinit;
  assign do_rd = rd && !empty && !reinit;
  assign waddr = wp_q;
  assign raddr = rp_q;
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || reinit) begin
      wp_q  <= base;
      rp_q  <= base;
      cnt_q <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else begin
      if (do_wr) wp_q <= (wp_q == last) ? base : wp_q + 1'b1;
      if (do_rd) rp_q <= (rp_q == last) ? base : rp_q + 1'b1;
      cnt_q <= cnt_q + {{(CW-1){1'b0}}, do_wr} - {{(CW-1){1'b0}}, do_rd};
      ovf   <= wr && full;
      unf   <= rd && empty;
    end
  end

endmodule

// File: rtl/ptag_fifo.sv
module ptag_fifo #(
  parameter int DEPTH     = 128,
  parameter int DW        = 8,
  parameter int BOUND_RST = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int EW = DW + 1,
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr_data,
  input  logic          host_wr_cmd,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  output logic [EW-1:0] host_rdata,
  output logic          host_ovf,
  output logic          host_unf,
  input  logic          loc_wr_data,
  input  logic          loc_wr_cmd,
  input  logic [DW-1:0] loc_wdata,
  input  logic          loc_rd,
  output logic [EW-1:0] loc_rdata,
  output logic          loc_ovf,
  output logic          loc_unf,
  input  logic          freeze,
  input  logic          bnd_we,
  input  logic [AW-1:0] bnd_wdata,
  output logic          in_full,
  output logic          in_empty,
  output logic [CW-1:0] in_count,
  output logic          out_full,
  output logic          out_empty,
  output logic [CW-1:0] out_count
);
  import ptf_pkg::*;

  // Boundary register
  logic [AW-1:0] bound_q;
  logic          bnd_ok;
  logic [AW-1:0] bound_nx;

  assign bnd_ok   = bnd_we && freeze;
  assign bound_nx = bnd_ok ? bnd_wdata : bound_q;

  always_ff @(posedge clk) begin
    if (rst)         bound_q <= AW'(BOUND_RST);
    else if (bnd_ok) bound_q <= bnd_wdata;
  end

  // Write strobes merged, command wins the tag
  ptf_tag_e h_tag, l_tag;
  logic     h_wr, l_wr;
  assign h_wr  = host_wr_data || host_wr_cmd;
  assign l_wr  = loc_wr_data || loc_wr_cmd;
  assign h_tag = host_wr_cmd ? TAG_CMD : TAG_DATA;
  assign l_tag = loc_wr_cmd ? TAG_CMD : TAG_DATA;

  // Queue geometry
  logic          hold_mode;
  logic [CW-1:0] in_cap, out_cap;
  logic [AW-1:0] in_last;
  assign hold_mode = (bound_q == '0);
  assign in_cap    = hold_mode ? CW'(1) : {1'b0, bound_q};
  assign out_cap   = CW'(DEPTH) - {1'b0, bound_q};
  assign in_last   = bound_q - 1'b1;

  // Inbound queue (host -> local)
  logic          in_do_wr, in_do_rd;
  logic [AW-1:0] in_waddr, in_raddr;

  ptf_chan #(.AW(AW)) u_in (
    .clk(clk), .rst(rst), .reinit(bnd_ok),
    .base('0), .last(in_last), .cap(in_cap),
    .wr(h_wr), .rd(loc_rd),
    .do_wr(in_do_wr), .do_rd(in_do_rd),
    .waddr(in_waddr), .raddr(in_raddr),
    .count(in_count), .full(in_full), .empty(in_empty),
    .ovf(host_ovf), .unf(loc_unf)
  );

  // Outbound queue (local -> host)
  logic          out_do_wr, out_do_rd;
  logic [AW-1:0] out_waddr, out_raddr;

  ptf_chan #(.AW(AW)) u_out (
    .clk(clk), .rst(rst), .reinit(bnd_ok),
    .base(bound_nx), .last(AW'(DEPTH - 1)), .cap(out_cap),
    .wr(l_wr), .rd(host_rd),
    .do_wr(out_do_wr), .do_rd(out_do_rd),
    .waddr(out_waddr), .raddr(out_raddr),
    .count(out_count), .full(out_full), .empty(out_empty),
    .ovf(loc_ovf), .unf(host_unf)
  );

  // Shared array
  logic [EW-1:0] arr_rd_in;

  ptf_mem #(.DEPTH(DEPTH), .EW(EW)) u_mem (
    .clk(clk), .rst(rst),
    .we_a(in_do_wr && !hold_mode), .wa_a(in_waddr), .wd_a({h_tag, host_wdata}),
    .we_b(out_do_wr), .wa_b(out_waddr), .wd_b({l_tag, loc_wdata}),
    .re_a(in_do_rd && !hold_mode), .ra_a(in_raddr), .rd_a(arr_rd_in),
    .re_b(out_do_rd), .ra_b(out_raddr), .rd_b(host_rdata)
  );

  // Depth-one inbound path used when the boundary is zero
  logic [EW-1:0] hold_q, hold_out_q;
  logic          sel_hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= '0;
      hold_out_q <= '0;
      sel_hold_q <= 1'b0;
    end else begin
      if (in_do_wr && hold_mode) hold_q <= {h_tag, host_wdata};
      if (in_do_rd) begin
        sel_hold_q <= hold_mode;
        if (hold_mode) hold_out_q <= hold_q;
      end
    end
  end

  assign loc_rdata = sel_hold_q ? hold_out_q : arr_rd_in;

endmodule

// File: rtl/ptag_fifo_chk.sv
module ptag_fifo_chk #(
  parameter int DEPTH = 128,
  parameter int AW    = 7,
  parameter int CW    = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          host_wr_data,
  input logic          host_wr_cmd,
  input logic          loc_rd,
  input logic          host_ovf,
  input logic          loc_unf,
  input logic          loc_ovf,
  input logic          host_unf,
  input logic          freeze,
  input logic          bnd_we,
  input logic [AW-1:0] bound,
  input logic          in_full,
  input logic          in_empty,
  input logic [CW-1:0] in_count,
  input logic          out_full,
  input logic          out_empty,
  input logic [CW-1:0] out_count
);

  logic [CW-1:0] in_room, out_room;
  assign in_room  = (bound == '0) ? CW'(1) : {1'b0, bound};
  assign out_room = CW'(DEPTH) - {1'b0, bound};

  // R4
  in_cap_chk: assert property (@(posedge clk) disable iff (rst)
    in_count <= in_room);

  // R4
  out_cap_chk: assert property (@(posedge clk) disable iff (rst)
    out_count <= out_room);

  // R5
  host_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    host_ovf |-> $past(in_full));

  // R5
  loc_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    loc_ovf |-> $past(out_full));

  // R6
  loc_unf_chk: assert property (@(posedge clk) disable iff (rst)
    loc_unf |-> $past(in_empty));

  // R6
  host_unf_chk: assert property (@(posedge clk) disable iff (rst)
    host_unf |-> $past(out_empty));

  // R5
  full_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_full && (host_wr_data || host_wr_cmd) && !loc_rd && !(bnd_we && freeze))
      |=> in_full);

  // R7
  reload_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bnd_we && freeze) |=> (in_count == '0 && out_count == '0));

  // R8
  frozen_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (bnd_we && !freeze) |=> $stable(bound));

endmodule

bind ptag_fifo ptag_fifo_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst),
  .host_wr_data(host_wr_data), .host_wr_cmd(host_wr_cmd), .loc_rd(loc_rd),
  .host_ovf(host_ovf), .loc_unf(loc_unf), .loc_ovf(loc_ovf), .host_unf(host_unf),
  .freeze(freeze), .bnd_we(bnd_we), .bound(bound_q),
  .in_full(in_full), .in_empty(in_empty), .in_count(in_count),
  .out_full(out_full), .out_empty(out_empty), .out_count(out_count)
);

// File: tb/sim_ptag_fifo.sv
`timescale 1ns/1ps
module sim_ptag_fifo;

  logic       clk = 1'b0;
  logic       rst;
  logic       host_wr_data, host_wr_cmd, host_rd;
  logic [7:0] host_wdata;
  logic [8:0] host_rdata;
  logic       host_ovf, host_unf;
  logic       loc_wr_data, loc_wr_cmd, loc_rd;
  logic [7:0] loc_wdata;
  logic [8:0] loc_rdata;
  logic       loc_ovf, loc_unf;
  logic       freeze, bnd_we;
  logic [6:0] bnd_wdata;
  logic       in_full, in_empty, out_full, out_empty;
  logic [7:0] in_count, out_count;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ptag_fifo u0 (
    .clk(clk), .rst(rst),
    .host_wr_data(host_wr_data), .host_wr_cmd(host_wr_cmd), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .host_ovf(host_ovf), .host_unf(host_unf),
    .loc_wr_data(loc_wr_data), .loc_wr_cmd(loc_wr_cmd), .loc_wdata(loc_wdata),
    .loc_rd(loc_rd), .loc_rdata(loc_rdata), .loc_ovf(loc_ovf), .loc_unf(loc_unf),
    .freeze(freeze), .bnd_we(bnd_we), .bnd_wdata(bnd_wdata),
    .in_full(in_full), .in_empty(in_empty), .in_count(in_count),
    .out_full(out_full), .out_empty(out_empty), .out_count(out_count)
  );

  typedef struct packed {
    logic       hd; logic hc; logic [7:0] hw; logic hr;
    logic       ld; logic lc; logic [7:0] lw; logic lr;
    logic [7:0] ein; logic [7:0] eout;
    logic       cl; logic [8:0] el;
    logic       ch; logic [8:0] eh;
  } vec_t;

  // R2 R3 R11 R12: mixed traffic starting from an empty block, boundary 64
  localparam vec_t VECS [0:12] = '{
    '{1'b1,1'b0,8'h11,1'b0, 1'b0,1'b0,8'h00,1'b0, 8'd1,8'd0, 1'b0,9'h000, 1'b0,9'h000},
    '{1'b0,1'b1,8'h22,1'b0, 1'b0,1'b0,8'h00,1'b0, 8'd2,8'd0, 1'b0,9'h000, 1'b0,9'h000},
    '{1'b0,1'b0,8'h00,1'b0, 1'b1,1'b0,8'h33,1'b0, 8'd2,8'd1, 1'b0,9'h000, 1'b0,9'h000},
    '{1'b0,1'b0,8'h00,1'b0, 1'b0,1'b1,8'h44,1'b0, 8'd2,8'd2, 1'b0,9'h000, 1'b0,9'h000},
    '{1'b0,1'b0,8'h00,1'b0, 1'b0,1'b0,8'h00,1'b1, 8'd1,8'd2, 1'b1,9'h011, 1'b0,9'h000},
    '{1'b0,1'b0,8'h00,1'b1, 1'b0,1'b0,8'h00,1'b0, 8'd1,8'd1, 1'b0,9'h000, 1'b1,9'h033},
    '{1'b0,1'b0,8'h00,1'b1, 1'b0,1'b0,8'h00,1'b1, 8'd0,8'd0, 1'b1,9'h122, 1'b1,9'h144},
    '{1'b1,1'b0,8'h55,1'b0, 1'b0,1'b1,8'h66,1'b0, 8'd1,8'd1, 1'b0,9'h000, 1'b0,9'h000},
    '{1'b1,1'b0,8'h77,1'b0, 1'b0,1'b0,8'h00,1'b1, 8'd1,8'd1, 1'b1,9'h055, 1'b0,9'h000},
    '{1'b1,1'b1,8'h88,1'b0, 1'b0,1'b0,8'h00,1'b0, 8'd2,8'd1, 1'b0,9'h000, 1'b0,9'h000},
    '{1'b0,1'b0,8'h00,1'b0, 1'b0,1'b0,8'h00,1'b1, 8'd1,8'd1, 1'b1,9'h077, 1'b0,9'h000},
    '{1'b0,1'b0,8'h00,1'b0, 1'b0,1'b0,8'h00,1'b1, 8'd0,8'd1, 1'b1,9'h188, 1'b0,9'h000},
    '{1'b0,1'b0,8'h00,1'b1, 1'b0,1'b0,8'h00,1'b0, 8'd0,8'd0, 1'b0,9'h000, 1'b1,9'h166}
  };

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  task automatic idle();
    host_wr_data = 0; host_wr_cmd = 0; host_wdata = 0; host_rd = 0;
    loc_wr_data = 0; loc_wr_cmd = 0; loc_wdata = 0; loc_rd = 0;
    bnd_we = 0; bnd_wdata = 0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic host_put(input logic cmd, input logic [7:0] b);
    host_wr_cmd = cmd; host_wr_data = !cmd; host_wdata = b;
    step(); idle();
  endtask

  task automatic loc_put(input logic cmd, input logic [7:0] b);
    loc_wr_cmd = cmd; loc_wr_data = !cmd; loc_wdata = b;
    step(); idle();
  endtask

  task automatic loc_get(input string req, input logic [8:0] e);
    loc_rd = 1; step(); idle();
    chk(req, loc_rdata, e);
  endtask

  task automatic host_get(input string req, input logic [8:0] e);
    host_rd = 1; step(); idle();
    chk(req, host_rdata, e);
  endtask

  task automatic set_bound(input logic frz, input logic [6:0] b);
    freeze = frz; bnd_we = 1; bnd_wdata = b;
    step(); idle(); freeze = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    idle(); freeze = 0; rst = 1;
    repeat (3) step();
    rst = 0;
    step();

    // R1 reset state
    chk("R1 in_count", in_count, 0);
    chk("R1 out_count", out_count, 0);
    chk("R1 empties", {in_empty, out_empty}, 2'b11);
    chk("R1 fulls", {in_full, out_full}, 2'b00);
    chk("R1 strobes", {host_ovf, host_unf, loc_ovf, loc_unf}, 0);
    chk("R1 rdata", {host_rdata, loc_rdata}, 0);

    // Vector table
    for (int k = 0; k < 13; k++) begin
      host_wr_data = VECS[k].hd; host_wr_cmd = VECS[k].hc; host_wdata = VECS[k].hw;
      host_rd = VECS[k].hr;
      loc_wr_data = VECS[k].ld; loc_wr_cmd = VECS[k].lc; loc_wdata = VECS[k].lw;
      loc_rd = VECS[k].lr;
      step(); idle();
      chk($sformatf("R11 vec%0d in_count", k), in_count, VECS[k].ein);
      chk($sformatf("R11 vec%0d out_count", k), out_count, VECS[k].eout);
      if (VECS[k].cl) chk($sformatf("R2 R12 vec%0d loc_rdata", k), loc_rdata, VECS[k].el);
      if (VECS[k].ch) chk($sformatf("R3 vec%0d host_rdata", k), host_rdata, VECS[k].eh);
    end

    // R1 R4 inbound capacity at the reset boundary 64
    for (int i = 0; i < 63; i++) host_put(1'b0, 8'(i));
    chk("R4 in not full at 63", in_full, 0);
    host_put(1'b0, 8'd63);
    chk("R1 R4 in_count 64", in_count, 64);
    chk("R4 in_full", in_full, 1);
    // R5 overflow
    host_put(1'b0, 8'hEE);
    chk("R5 host_ovf", host_ovf, 1);
    chk("R5 in_count held", in_count, 64);
    step();
    chk("R5 host_ovf one cycle", host_ovf, 0);
    for (int i = 0; i < 64; i++) loc_get("R5 drain order", {1'b0, 8'(i)});
    chk("R4 in_empty", in_empty, 1);
    // R6 underflow
    loc_rd = 1; step(); idle();
    chk("R6 loc_unf", loc_unf, 1);
    chk("R6 loc_rdata held", loc_rdata, 9'h03F);
    step();
    chk("R6 loc_unf one cycle", loc_unf, 0);

    // R9 inbound wrap within 0..63
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 40; i++) host_put(i[0], 8'(r * 40 + i));
      for (int i = 0; i < 40; i++) loc_get("R9 wrap order", {i[0], 8'(r * 40 + i)});
    end

    // R4 R5 R6 outbound channel
    for (int i = 0; i < 64; i++) loc_put(i[0], 8'(8'h80 + i));
    chk("R4 out_full", out_full, 1);
    loc_put(1'b0, 8'hEE);
    chk("R5 loc_ovf", loc_ovf, 1);
    chk("R5 out_count held", out_count, 64);
    for (int i = 0; i < 64; i++) host_get("R3 R9 out order", {i[0], 8'(8'h80 + i)});
    host_rd = 1; step(); idle();
    chk("R6 host_unf", host_unf, 1);
    chk("R6 host_rdata held", host_rdata, 9'h1BF);

    // R8 boundary write without freeze
    host_put(1'b0, 8'hA0); host_put(1'b1, 8'hA1); host_put(1'b0, 8'hA2);
    set_bound(1'b0, 7'h10);
    chk("R8 in_count kept", in_count, 3);
    loc_get("R8 contents kept", 9'h0A0);
    loc_get("R8 contents kept", 9'h1A1);
    loc_get("R8 contents kept", 9'h0A2);
    for (int i = 0; i < 64; i++) loc_put(1'b0, 8'(i));
    chk("R8 out capacity still 64", out_full, 1);
    for (int i = 0; i < 64; i++) host_get("R8 drain", {1'b0, 8'(i)});

    // R7 boundary reload with freeze
    host_put(1'b0, 8'h01); host_put(1'b0, 8'h02); loc_put(1'b1, 8'h03);
    set_bound(1'b1, 7'h10);
    chk("R7 in_count cleared", in_count, 0);
    chk("R7 out_count cleared", out_count, 0);
    chk("R7 empties", {in_empty, out_empty}, 2'b11);
    for (int i = 0; i < 15; i++) host_put(1'b0, 8'(i));
    chk("R4 R7 not full at 15", in_full, 0);
    host_put(1'b0, 8'd15);
    chk("R4 R7 in full at 16", in_full, 1);
    for (int i = 0; i < 112; i++) loc_put(1'b0, 8'(i));
    chk("R4 R7 out full at 112", {out_full, out_count}, {1'b1, 8'd112});
    for (int i = 0; i < 16; i++) loc_get("R7 R9 in drain", {1'b0, 8'(i)});
    for (int i = 0; i < 112; i++) host_get("R7 R9 out drain", {1'b0, 8'(i)});

    // R10 boundary zero: holding register inbound, full array outbound
    set_bound(1'b1, 7'h00);
    host_put(1'b1, 8'hA5);
    chk("R10 in_count 1", in_count, 1);
    chk("R10 in_full", in_full, 1);
    host_put(1'b0, 8'h5A);
    chk("R10 R5 ovf", host_ovf, 1);
    loc_get("R10 hold entry", 9'h1A5);
    chk("R10 in_empty", in_empty, 1);
    host_put(1'b0, 8'h3C);
    loc_get("R10 hold entry 2", 9'h03C);
    for (int i = 0; i < 128; i++) loc_put(1'b0, 8'(i));
    chk("R10 out 128", {out_full, out_count}, {1'b1, 8'd128});
    for (int i = 0; i < 128; i++) host_get("R10 out drain", {1'b0, 8'(i)});

    // R4 boundary at top: outbound capacity 1
    set_bound(1'b1, 7'h7F);
    loc_put(1'b1, 8'h99);
    chk("R4 out cap 1", {out_full, out_count}, {1'b1, 8'd1});
    host_get("R4 out single entry", 9'h199);

    finish_run();
  end

endmodule